// File: doc/BRIEF.md
# Cartridge Bus Window Decoder with Control Registers

This block sits on the console side of a cartridge. It takes a strobed, byte-addressed word access from the console's parallel bus and works out which of three address windows the access belongs to. The first is a 64 MB main-memory window. The second is a 2 kB save-memory window. The third is a two-word control register bank. For the two memory windows it raises one select strobe in the same cycle as the request. Register accesses it serves itself, and it returns their read data one cycle later.

Two registers live in the bank. A configuration word turns on the main memory, turns on the save memory, and picks the size identity the save engine reports. A 32-bit boot-override word carries a CIC type, a TV type and spare switch bits to the boot code.

When main memory is disabled, the main-memory window is redirected to the boot flash. Power-up reset clears both registers. A console reset/NMI pulse clears only the main-memory enable, so the boot flash comes back at the next boot while the save settings survive.

Top module: `cart_bus_decoder`

## Requirements
- R1: With the memory-enable bit (configuration bit 1) set, an access to 0x1000_0000..0x13FF_FFFF with byte address bit 0 clear raises `sel_sdram_o` in the same cycle as `req_i`.
- R2: With the memory-enable bit clear, the same access raises `sel_flash_o` instead, and `sel_sdram_o` stays low.
- R3: An access to 0x1D00_0000..0x1D00_07FF with address bits 1:0 zero raises `sel_save_o` only while the save-enable bit (configuration bit 3) is set. Otherwise the access raises no select.
- R4: A write to the configuration word (0x1E00_0000) stores only bits 1, 3 and 4. Reading it back returns zero in bits 0, 2 and 31:5.
- R5: The boot-override word (0x1E00_0004) stores all 32 written bits: CIC type in 3:0, TV type in 5:4, switches in 31:6. It reads them back unchanged, and `boot_ovr_o` shows the stored value.
- R6: A read that raises no memory select gives `rvalid_o` high for exactly the next cycle, with `rdata_o` valid in that cycle. A read that raises a memory select gives no `rvalid_o`.
- R7: An access outside all three windows, or one that is misaligned for its window, raises no select and changes no register, and a read of it returns zero.
- R8: An `nmi_i` pulse clears the memory-enable bit. It leaves configuration bits 4:3 and the boot-override word unchanged, and it wins over a same-cycle write of bit 1.
- R9: Asserting `rst_ni` low clears both registers to zero and drops `rvalid_o`.
- R10: At most one of `sel_sdram_o`, `sel_flash_o` and `sel_save_o` is high in any cycle.
- R11: `mem_en_o`, `save_en_o` and `save_16k_o` show configuration bits 1, 3 and 4 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-up reset, asynchronous, active low |
| nmi_i | input | 1 | Console reset/NMI event, one-cycle pulse |
| req_i | input | 1 | Access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Write data |
| sel_sdram_o | output | 1 | Main-memory window routed to external memory |
| sel_flash_o | output | 1 | Main-memory window routed to boot flash |
| sel_save_o | output | 1 | Save-memory window select |
| rvalid_o | output | 1 | Register-path read data valid |
| rdata_o | output | 32 | Register-path read data |
| mem_en_o | output | 1 | Memory-enable bit |
| save_en_o | output | 1 | Save-enable bit |
| save_16k_o | output | 1 | Save size identity, 1 = 16k |
| boot_ovr_o | output | 32 | Boot-override word |

## Verification
Some properties are checked on every cycle. The selects stay one-hot. A select only appears while its enable bit allows it. An NMI always leaves the memory enable low and keeps the save bits. `rvalid_o` follows exactly the reads that raised no memory select. Reads outside the bank return zero, and reserved configuration bits read as zero.

Other behaviour only the bench scenarios can show. These cover the exact window edges, such as the last word of each window and the first address past it. They also cover full 32-bit write-and-readback of the boot word, and that misaligned or out-of-bank writes leave stored values unchanged. Finally, they check what an NMI does when it coincides with a configuration write, and that a mid-run power-up reset clears state.

// File: rtl/cart_dec_pkg.sv
package cart_dec_pkg;
  localparam int NUM_WIN  = 3;
  localparam int WIN_MEM  = 0;
  localparam int WIN_SAVE = 1;
  localparam int WIN_REG  = 2;

  typedef struct packed {
    logic save_16k;
    logic save_en;
    logic mem_en;
  } cfg_t;
endpackage

// File: rtl/cart_addr_decode.sv
module cart_addr_decode
  import cart_dec_pkg::*;
#(
  parameter int                      ADDR_W = 32,
  parameter logic [NUM_WIN*32-1:0]   BASES  = '0,
  parameter logic [NUM_WIN*8-1:0]    SPANS  = '0,  // log2 window size in bytes
  parameter logic [NUM_WIN*8-1:0]    ALIGNS = '0   // log2 access size in bytes
) (
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_WIN-1:0] hit_o
);
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam int          SPAN  = int'(SPANS[w*8 +: 8]);
    localparam int          ALIGN = int'(ALIGNS[w*8 +: 8]);
    localparam logic [31:0] BASE  = BASES[w*32 +: 32];
    logic in_range, aligned;
    assign in_range = addr_i[ADDR_W-1:SPAN] == BASE[ADDR_W-1:SPAN];
    assign aligned  = addr_i[ALIGN-1:0] == '0;
    assign hit_o[w] = req_i && in_range && aligned;
  end
endmodule

// File: rtl/cart_ctrl_regs.sv
module cart_ctrl_regs
  import cart_dec_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int IDX_W       = 1,
  parameter int MEM_EN_BIT  = 1,
  parameter int SAVE_EN_BIT = 3,
  parameter int SAVE_SZ_BIT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              nmi_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic              rd_hit_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output cfg_t              cfg_o,
  output logic [DATA_W-1:0] boot_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [IDX_W-1:0] IDX_CFG  = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_BOOT = IDX_W'(1);

  cfg_t              cfg_q;
  logic [DATA_W-1:0] boot_q;
  logic [DATA_W-1:0] cfg_word, rd_mux;

  always_comb begin
    cfg_word              = '0;
    cfg_word[MEM_EN_BIT]  = cfg_q.mem_en;
    cfg_word[SAVE_EN_BIT] = cfg_q.save_en;
    cfg_word[SAVE_SZ_BIT] = cfg_q.save_16k;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else begin
      if (wr_en_i && idx_i == IDX_CFG) begin
        cfg_q.mem_en   <= wdata_i[MEM_EN_BIT];
        cfg_q.save_en  <= wdata_i[SAVE_EN_BIT];
        cfg_q.save_16k <= wdata_i[SAVE_SZ_BIT];
      end
      // console reset/NMI wins over a same-cycle write
      if (nmi_i) cfg_q.mem_en <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             boot_q <= '0;
    else if (wr_en_i && idx_i == IDX_BOOT)   boot_q <= wdata_i;
  end

  always_comb begin
    rd_mux = '0;
    if (rd_hit_i) rd_mux = (idx_i == IDX_BOOT) ? boot_q : cfg_word;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_en_i;
      rdata_o  <= rd_en_i ? rd_mux : '0;
    end
  end

  assign cfg_o  = cfg_q;
  assign boot_o = boot_q;
endmodule

// File: rtl/cart_bus_decoder.sv
module cart_bus_decoder
  import cart_dec_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 32,
  parameter logic [31:0] MEM_BASE  = 32'h1000_0000,
  parameter int          MEM_LOG2  = 26,
  parameter logic [31:0] SAVE_BASE = 32'h1D00_0000,
  parameter int          SAVE_LOG2 = 11,
  parameter logic [31:0] REG_BASE  = 32'h1E00_0000,
  parameter int          REG_WORDS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              nmi_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              sel_sdram_o,
  output logic              sel_flash_o,
  output logic              sel_save_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_en_o,
  output logic              save_en_o,
  output logic              save_16k_o,
  output logic [DATA_W-1:0] boot_ovr_o
);
  localparam int IDX_W    = (REG_WORDS > 1) ? $clog2(REG_WORDS) : 1;
  localparam int REG_LOG2 = IDX_W + 2;

  localparam logic [NUM_WIN*32-1:0] BASES  = {REG_BASE, SAVE_BASE, MEM_BASE};
  localparam logic [NUM_WIN*8-1:0]  SPANS  = {8'(REG_LOG2), 8'(SAVE_LOG2), 8'(MEM_LOG2)};
  localparam logic [NUM_WIN*8-1:0]  ALIGNS = {8'd2, 8'd2, 8'd1};

  logic [NUM_WIN-1:0] hit;
  cfg_t               cfg;
  logic               mem_sel_any;

  cart_addr_decode #(
    .ADDR_W(ADDR_W), .BASES(BASES), .SPANS(SPANS), .ALIGNS(ALIGNS)
  ) u_dec (
    .req_i (req_i),
    .addr_i(addr_i),
    .hit_o (hit)
  );

  assign sel_sdram_o = hit[WIN_MEM] &&  cfg.mem_en;
  assign sel_flash_o = hit[WIN_MEM] && !cfg.mem_en;
  assign sel_save_o  = hit[WIN_SAVE] && cfg.save_en;
  assign mem_sel_any = sel_sdram_o || sel_flash_o || sel_save_o;

  cart_ctrl_regs #(
    .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .nmi_i   (nmi_i),
    .wr_en_i (we_i && hit[WIN_REG]),
    .rd_en_i (req_i && !we_i && !mem_sel_any),
    .rd_hit_i(hit[WIN_REG]),
    .idx_i   (addr_i[REG_LOG2-1:2]),
    .wdata_i (wdata_i),
    .cfg_o   (cfg),
    .boot_o  (boot_ovr_o),
    .rvalid_o(rvalid_o),
    .rdata_o (rdata_o)
  );

  assign mem_en_o   = cfg.mem_en;
  assign save_en_o  = cfg.save_en;
  assign save_16k_o = cfg.save_16k;
endmodule

// File: rtl/cart_bus_decoder_chk.sv
module cart_bus_decoder_chk #(
  parameter logic [31:0] REG_BASE = 32'h1E00_0000
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        nmi_i,
  input logic        req_i,
  input logic        we_i,
  input logic [31:0] addr_i,
  input logic        sel_sdram_o,
  input logic        sel_flash_o,
  input logic        sel_save_o,
  input logic        rvalid_o,
  input logic [31:0] rdata_o,
  input logic        mem_en_o,
  input logic        save_en_o,
  input logic        save_16k_o
);
  logic any_sel, reg_rd;
  assign any_sel = sel_sdram_o || sel_flash_o || sel_save_o;
  assign reg_rd  = req_i && !we_i && !any_sel;

  p_sel_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sel_sdram_o, sel_flash_o, sel_save_o}));

  p_sdram_needs_en_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_sdram_o |-> mem_en_o && req_i);

  p_flash_when_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_flash_o |-> !mem_en_o && req_i);

  p_save_gated_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_save_o |-> save_en_o && req_i);

  p_rvalid_after_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd |=> rvalid_o);

  p_no_spurious_rvalid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rd |=> !rvalid_o);

  p_outside_reads_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd && addr_i[31:3] != REG_BASE[31:3] |=> rdata_o == '0);

  p_cfg_reserved_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd && addr_i == REG_BASE |=>
      rdata_o[31:5] == '0 && !rdata_o[2] && !rdata_o[0]);

  p_nmi_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_i |=> !mem_en_o);

  p_nmi_keeps_save_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_i && !(req_i && we_i) |=> $stable(save_en_o) && $stable(save_16k_o));
endmodule

bind cart_bus_decoder cart_bus_decoder_chk #(.REG_BASE(REG_BASE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .nmi_i(nmi_i), .req_i(req_i), .we_i(we_i),
  .addr_i(addr_i), .sel_sdram_o(sel_sdram_o), .sel_flash_o(sel_flash_o),
  .sel_save_o(sel_save_o), .rvalid_o(rvalid_o), .rdata_o(rdata_o),
  .mem_en_o(mem_en_o), .save_en_o(save_en_o), .save_16k_o(save_16k_o)
);

// File: tb/sim_cart_bus_decoder.sv
`timescale 1ns/1ps
module sim_cart_bus_decoder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        nmi_i = 1'b0, req_i = 1'b0, we_i = 1'b0;
  logic [31:0] addr_i = '0, wdata_i = '0;
  logic        sel_sdram_o, sel_flash_o, sel_save_o, rvalid_o;
  logic [31:0] rdata_o, boot_ovr_o;
  logic        mem_en_o, save_en_o, save_16k_o;

  always #2 clk_i = ~clk_i;

  cart_bus_decoder u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .nmi_i(nmi_i), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .sel_sdram_o(sel_sdram_o),
    .sel_flash_o(sel_flash_o), .sel_save_o(sel_save_o), .rvalid_o(rvalid_o),
    .rdata_o(rdata_o), .mem_en_o(mem_en_o), .save_en_o(save_en_o),
    .save_16k_o(save_16k_o), .boot_ovr_o(boot_ovr_o)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // reference state
  logic [31:0] m_cfg = '0, m_boot = '0, m_rd = '0;
  bit          m_rv = 0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_regs();
    chk(32'(rvalid_o), 32'(m_rv), "R6 rvalid");
    if (m_rv) chk(rdata_o, m_rd, "R6/R4/R5/R7 rdata");
    chk(32'(mem_en_o),   32'(m_cfg[1]), "R11 mem_en");
    chk(32'(save_en_o),  32'(m_cfg[3]), "R11 save_en");
    chk(32'(save_16k_o), 32'(m_cfg[4]), "R11 save_16k");
    chk(boot_ovr_o, m_boot, "R5 boot_ovr");
  endtask

  task automatic cyc(input bit rq, input bit wr, input logic [31:0] a,
                     input logic [31:0] d, input bit nmi);
    bit in_mem, in_save, in_reg, e_sd, e_fl, e_sv;
    @(negedge clk_i);
    check_regs();
    req_i = rq; we_i = wr; addr_i = a; wdata_i = d; nmi_i = nmi;
    #1;
    in_mem  = a >= 32'h1000_0000 && a <= 32'h13FF_FFFF && (a % 2) == 0;
    in_save = a >= 32'h1D00_0000 && a <= 32'h1D00_07FF && (a % 4) == 0 && m_cfg[3];
    in_reg  = a >= 32'h1E00_0000 && a <= 32'h1E00_0007 && (a % 4) == 0;
    e_sd = rq && in_mem && m_cfg[1];
    e_fl = rq && in_mem && !m_cfg[1];
    e_sv = rq && in_save;
    chk(32'(sel_sdram_o), 32'(e_sd), "R1 sel_sdram");
    chk(32'(sel_flash_o), 32'(e_fl), "R2 sel_flash");
    chk(32'(sel_save_o),  32'(e_sv), "R3 sel_save");
    chk(32'(sel_sdram_o + sel_flash_o + sel_save_o <= 1), 32'd1, "R10 onehot");
    m_rv = rq && !wr && !(in_mem || in_save);
    m_rd = (m_rv && in_reg) ? (a[2] ? m_boot : m_cfg) : 32'h0;
    if (rq && wr && in_reg) begin
      if (a[2]) m_boot = d;
      else      m_cfg  = d & 32'h1A;
    end
    if (nmi) m_cfg = m_cfg & ~32'h2;
  endtask

  task automatic rd(input logic [31:0] a);      cyc(1, 0, a, '0, 0); endtask
  task automatic wr(input logic [31:0] a, input logic [31:0] d); cyc(1, 1, a, d, 0); endtask
  task automatic idle();                         cyc(0, 0, '0, '0, 0); endtask

  task automatic power_reset();
    @(negedge clk_i);
    req_i = 0; we_i = 0; nmi_i = 0;
    rst_ni = 0;
    m_cfg = '0; m_boot = '0; m_rv = 0; m_rd = '0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    power_reset();
    // R9: reset state
    idle();
    chk(32'(mem_en_o | save_en_o | save_16k_o | rvalid_o), 32'd0, "R9 reset status");
    chk(boot_ovr_o, 32'd0, "R9 reset boot");
    rd(32'h1E00_0000); rd(32'h1E00_0004);
    // R2: memory disabled -> flash
    rd(32'h1000_0000); rd(32'h13FF_FFFE); wr(32'h1200_0010, 32'h1234);
    // R4: only bits 1,3,4 stored
    wr(32'h1E00_0000, 32'hFFFF_FFFF); rd(32'h1E00_0000);
    // R1: memory enabled -> sdram, window edges
    rd(32'h1000_0000); rd(32'h13FF_FFFE); wr(32'h1100_0002, 32'h5);
    // R7: misaligned / outside main window
    rd(32'h1000_0001); rd(32'h1400_0000); rd(32'h0FFF_FFFE);
    // R3: save window enabled
    rd(32'h1D00_0000); rd(32'h1D00_07FC); rd(32'h1D00_0800); rd(32'h1D00_0002);
    // R5: boot-override full width
    wr(32'h1E00_0004, 32'hDEAD_BEEF); rd(32'h1E00_0004);
    wr(32'h1E00_0004, 32'h0000_003D); rd(32'h1E00_0004);
    // R7: misaligned and out-of-bank register writes ignored
    wr(32'h1E00_0006, 32'hFFFF_FFFF); wr(32'h1E00_0008, 32'h0);
    wr(32'h1E00_0001, 32'h0); rd(32'h1E00_0004); rd(32'h1E00_0000);
    rd(32'h1E00_0008); rd(32'h2000_0000); rd(32'h1E00_0002);
    // R8: NMI clears memory enable only
    cyc(0, 0, '0, '0, 1); rd(32'h1E00_0000); rd(32'h1000_0100); rd(32'h1D00_0010);
    // R8: NMI beats same-cycle write of bit 1
    cyc(1, 1, 32'h1E00_0000, 32'h0000_0012, 1); rd(32'h1E00_0000);
    wr(32'h1E00_0000, 32'h0000_0002); rd(32'h1E00_0004);
    // R3: save disabled -> no select, read falls to register path as zero
    rd(32'h1D00_0000); rd(32'h1000_0000);
    // R10: sweep of mixed accesses
    for (int i = 0; i < 40; i++) begin
      cyc(1, i[0], 32'h1000_0000 + 32'(i) * 32'h0080_0000, 32'(i) * 32'h1357, 0);
      cyc(1, 0, 32'h1D00_0000 + 32'(i) * 4, '0, i % 7 == 0);
    end
    wr(32'h1E00_0000, 32'h0000_001A); rd(32'h1D00_0004);
    // R9: power-up reset mid-run
    power_reset();
    idle(); rd(32'h1E00_0000); rd(32'h1E00_0004); rd(32'h1000_0000);
    idle(); idle();
    finish_run();
  end
endmodule